// File: doc/BRIEF.md
# Display Interrupt Aggregation Controller

This block gathers interrupt events from a set of display pipes, a user/render event, an auxiliary backlight-request event and a group of port hotplug detectors, and turns them into one level interrupt line plus a single-cycle message-signalled pulse. Software sees a top-level identity register that records which sources fired, a mask register, an enable register, one status register per pipe and a pair of hotplug registers, all reached through a one-cycle synchronous read/write port.

Pipe events do not go straight to the identity register. Each pipe first keeps sticky status bits. Each status bit has an enable 16 positions higher in the same word. Only when an enabled status bit is pending does the pipe's identity bit see a rising edge. Hotplug detects work in a similar way: they are sticky per port, gated by a per-port enable, and collapsed into one identity bit. The message-signalled pulse marks only the cycle in which the identity register leaves the all-zero state. Software can therefore read a register and write the same value back to acknowledge exactly what it saw.

Top module: `dispirq_ctrl`

## Requirements
- R1: After reset the identity register (IIR) reads 0, the mask register (IMR) reads all ones over its width, the enable register (IER) has only bit 0 (user source) set, all pipe status and hotplug registers read 0, and both interrupt outputs are low.
- R2: Word addresses are 0 IIR, 1 IMR, 2 IER, 3 hotplug status, 4 hotplug enable, 8+p status of pipe p. A read returns its data on `reg_rdata` in the cycle after the read strobe. Any other address reads 0.
- R3: A pipe status word keeps event status bit n (n = 0..15) at bit n and an overflow status at bit 31. These bits are sticky and are cleared by writing 1. Bits 30:16 are read/write enables. Writing back a value just read clears exactly the pending bits and keeps the enables. An event in the same cycle as its clear leaves the bit set.
- R4: Status bit n of pipe p (n = 0..14) interrupts only when enable bit n+16 is set. It then sets IIR bit 3+p on the clock edge after the status bit sets. Status bits 15 and 31 never interrupt.
- R5: IIR bits are user = 0, aux = 1, hotplug = 2, pipe p = 3+p. A source sets its IIR bit only on a rising edge of the source, and only while its IER bit is 1 and its IMR bit is 0. A source that stays high does not set the bit again after it is cleared.
- R6: IIR bits clear when 1 is written to them. A source edge in the same cycle as the clear wins, and the bit stays set.
- R7: `irq_level` is high while any IIR bit is set or any pipe has an enabled pending status bit. Clearing a pipe's IIR bit while its status is still pending keeps `irq_level` high and does not set the IIR bit again.
- R8: `irq_msi` is high for exactly one cycle: the first cycle in which IIR is non-zero after having been zero. Further bits that set while IIR is non-zero produce no pulse.
- R9: Each hotplug detect sets a sticky status bit that is cleared by writing 1. IIR bit 2 sees a rising edge when any status bit with its hotplug enable bit set becomes pending, including when the enable is written while the status is already pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| user_evt | input | 1 | User/render event level |
| aux_evt | input | 1 | Backlight request event level |
| pipe_evt | input | NUM_PIPES*16 | Per-pipe event pulses, 16 per pipe |
| pipe_ovf | input | NUM_PIPES | Per-pipe overflow event pulses |
| hp_det | input | NUM_PORTS | Per-port hotplug detect pulses |
| irq_level | output | 1 | Level interrupt |
| irq_msi | output | 1 | One-cycle message-signalled interrupt pulse |

## Verification
The timing differs by path. User and aux edges reach IIR at the same edge that samples them. Pipe and hotplug events take one more edge, because they pass through their sticky status first. `irq_level` follows a pending enabled pipe status at once. `irq_msi` rises in the first cycle that IIR is non-zero. Read data appears one edge after the strobe. The bench drives on falling edges and samples after a falling edge. Before reading IIR after a pipe or hotplug event it inserts one extra cycle, and it checks `irq_msi` in the exact cycle IIR turns non-zero and again one cycle later.

// File: rtl/dispirq_pkg.sv
package dispirq_pkg;
   localparam int DATA_W      = 32;
   localparam int PST_EVT     = 16;   // event status bits per pipe
   localparam int PST_EN_LSB  = 16;   // enable for status n sits at n + 16
   localparam int PST_EN_W    = 15;   // bits 30:16
   localparam int PST_OVF_BIT = 31;

   localparam int IIR_USER  = 0;
   localparam int IIR_AUX   = 1;
   localparam int IIR_HP    = 2;
   localparam int IIR_PIPE0 = 3;

   localparam int A_IIR    = 0;
   localparam int A_IMR    = 1;
   localparam int A_IER    = 2;
   localparam int A_HPSTAT = 3;
   localparam int A_HPEN   = 4;
   localparam int A_PIPE0  = 8;
endpackage

// File: rtl/dispirq_pipe_stat.sv
module dispirq_pipe_stat
   import dispirq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [PST_EVT-1:0] evt,
   input  logic              ovf,
   output logic [DATA_W-1:0] word,
   output logic              pend
);
   logic [PST_EVT-1:0]  st_lo;
   logic                st_ovf;
   logic [PST_EN_W-1:0] en;
   logic [PST_EVT-1:0]  clr_lo;
   logic                clr_ovf;

   assign clr_lo  = wr ? wdata[PST_EVT-1:0] : '0;
   assign clr_ovf = wr & wdata[PST_OVF_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_lo  <= '0;
         st_ovf <= 1'b0;
         en     <= '0;
      end else begin
         // event has priority over a same-cycle clear
         st_lo  <= (st_lo & ~clr_lo) | evt;
         st_ovf <= (st_ovf & ~clr_ovf) | ovf;
         if (wr) en <= wdata[PST_EN_LSB +: PST_EN_W];
      end
   end

   assign word = {st_ovf, en, st_lo};
   assign pend = |(st_lo[PST_EN_W-1:0] & en);
endmodule

// File: rtl/dispirq_hotplug.sv
module dispirq_hotplug #(
   parameter int NUM_PORTS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_stat,
   input  logic                 wr_en,
   input  logic [NUM_PORTS-1:0] wdata,
   input  logic [NUM_PORTS-1:0] det,
   output logic [NUM_PORTS-1:0] stat,
   output logic [NUM_PORTS-1:0] en,
   output logic                 any
);
   logic [NUM_PORTS-1:0] clr;
   assign clr = wr_stat ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
         en   <= '0;
      end else begin
         stat <= (stat & ~clr) | det;
         if (wr_en) en <= wdata;
      end
   end

   assign any = |(stat & en);
endmodule

// File: rtl/dispirq_iir.sv
module dispirq_iir #(
   parameter int IIR_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IIR_W-1:0] src,
   input  logic [IIR_W-1:0] ier,
   input  logic [IIR_W-1:0] imr,
   input  logic [IIR_W-1:0] clr,
   output logic [IIR_W-1:0] iir,
   output logic             msi
);
   logic [IIR_W-1:0] src_q;
   logic [IIR_W-1:0] set;
   logic             nz_q;

   assign set = src & ~src_q & ier & ~imr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= '0;
         iir   <= '0;
         nz_q  <= 1'b0;
      end else begin
         src_q <= src;
         iir   <= (iir & ~clr) | set;
         nz_q  <= |iir;
      end
   end

   assign msi = (|iir) & ~nz_q;
endmodule

// File: rtl/dispirq_ctrl.sv
module dispirq_ctrl
   import dispirq_pkg::*;
#(
   parameter int NUM_PIPES = 2,
   parameter int NUM_PORTS = 4,
   parameter int ADDR_W    = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_wr,
   input  logic                    reg_rd,
   input  logic [ADDR_W-1:0]       reg_addr,
   input  logic [DATA_W-1:0]       reg_wdata,
   output logic [DATA_W-1:0]       reg_rdata,
   input  logic                    user_evt,
   input  logic                    aux_evt,
   input  logic [NUM_PIPES*PST_EVT-1:0] pipe_evt,
   input  logic [NUM_PIPES-1:0]    pipe_ovf,
   input  logic [NUM_PORTS-1:0]    hp_det,
   output logic                    irq_level,
   output logic                    irq_msi
);
   localparam int IIR_W = IIR_PIPE0 + NUM_PIPES;
   localparam logic [IIR_W-1:0] IER_RST = IIR_W'(1) << IIR_USER;

   if (NUM_PIPES < 1 || NUM_PIPES > 8) begin : g_bad_pipes
      $error("NUM_PIPES must be 1..8");
   end
   if (NUM_PORTS < 1 || NUM_PORTS > DATA_W) begin : g_bad_ports
      $error("NUM_PORTS must be 1..32");
   end
   if ((A_PIPE0 + NUM_PIPES) > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for pipe registers");
   end

   logic             sel_iir, sel_imr, sel_ier, sel_hps, sel_hpe;
   logic [IIR_W-1:0] imr_q, ier_q, iir_q, iir_clr, src;
   logic [NUM_PIPES-1:0] pipe_pend;
   logic [DATA_W-1:0] pst_word [NUM_PIPES];
   logic [NUM_PORTS-1:0] hp_stat, hp_en;
   logic             hp_any;
   logic [DATA_W-1:0] rd_mux;

   assign sel_iir = reg_addr == ADDR_W'(A_IIR);
   assign sel_imr = reg_addr == ADDR_W'(A_IMR);
   assign sel_ier = reg_addr == ADDR_W'(A_IER);
   assign sel_hps = reg_addr == ADDR_W'(A_HPSTAT);
   assign sel_hpe = reg_addr == ADDR_W'(A_HPEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         imr_q <= '1;
         ier_q <= IER_RST;
      end else if (reg_wr) begin
         if (sel_imr) imr_q <= reg_wdata[IIR_W-1:0];
         if (sel_ier) ier_q <= reg_wdata[IIR_W-1:0];
      end
   end

   assign iir_clr = (reg_wr && sel_iir) ? reg_wdata[IIR_W-1:0] : '0;

   for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
      dispirq_pipe_stat u_pst (
         .clk   (clk),
         .rst_n (rst_n),
         .wr    (reg_wr && (reg_addr == ADDR_W'(A_PIPE0 + p))),
         .wdata (reg_wdata),
         .evt   (pipe_evt[p*PST_EVT +: PST_EVT]),
         .ovf   (pipe_ovf[p]),
         .word  (pst_word[p]),
         .pend  (pipe_pend[p])
      );
   end

   dispirq_hotplug #(.NUM_PORTS(NUM_PORTS)) u_hp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stat (reg_wr && sel_hps),
      .wr_en   (reg_wr && sel_hpe),
      .wdata   (reg_wdata[NUM_PORTS-1:0]),
      .det     (hp_det),
      .stat    (hp_stat),
      .en      (hp_en),
      .any     (hp_any)
   );

   assign src = {pipe_pend, hp_any, aux_evt, user_evt};

   dispirq_iir #(.IIR_W(IIR_W)) u_iir (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (src),
      .ier   (ier_q),
      .imr   (imr_q),
      .clr   (iir_clr),
      .iir   (iir_q),
      .msi   (irq_msi)
   );

   assign irq_level = (|iir_q) | (|pipe_pend);

   always_comb begin
      rd_mux = '0;
      if (sel_iir) rd_mux = DATA_W'(iir_q);
      if (sel_imr) rd_mux = DATA_W'(imr_q);
      if (sel_ier) rd_mux = DATA_W'(ier_q);
      if (sel_hps) rd_mux = DATA_W'(hp_stat);
      if (sel_hpe) rd_mux = DATA_W'(hp_en);
      for (int p = 0; p < NUM_PIPES; p++) begin
         if (reg_addr == ADDR_W'(A_PIPE0 + p)) rd_mux = pst_word[p];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_mux;
   end
endmodule

// File: rtl/dispirq_ctrl_chk.sv
module dispirq_ctrl_chk
   import dispirq_pkg::*;
#(
   parameter int NUM_PIPES = 2
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          irq_level,
   input logic                          irq_msi,
   input logic [IIR_PIPE0+NUM_PIPES-1:0] iir_q,
   input logic [IIR_PIPE0+NUM_PIPES-1:0] imr_q,
   input logic [IIR_PIPE0+NUM_PIPES-1:0] iir_clr
);
   AST_MSI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_msi |=> !irq_msi); // R8
   AST_MSI_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      irq_msi |-> ($past(iir_q) == '0)); // R8
   AST_MSI_WITH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      irq_msi |-> irq_level); // R8
   AST_LEVEL_COVERS_IIR: assert property (@(posedge clk) disable iff (!rst_n)
      (|iir_q) |-> irq_level); // R7
   AST_MASKED_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> ((iir_q & ~$past(iir_q) & $past(imr_q)) == '0)); // R5
   AST_IIR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (($past(iir_q) & ~$past(iir_clr) & ~iir_q) == '0)); // R6
endmodule

bind dispirq_ctrl dispirq_ctrl_chk #(.NUM_PIPES(NUM_PIPES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_level (irq_level),
   .irq_msi   (irq_msi),
   .iir_q     (iir_q),
   .imr_q     (imr_q),
   .iir_clr   (iir_clr)
);

// File: tb/dispirq_ctrl_tb.sv
`timescale 1ns/1ps
module dispirq_ctrl_tb_top;
   localparam int NP = 2;
   localparam int NH = 4;
   localparam int AW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0, reg_rd = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic user_evt = 1'b0, aux_evt = 1'b0;
   logic [NP*16-1:0] pipe_evt = '0;
   logic [NP-1:0] pipe_ovf = '0;
   logic [NH-1:0] hp_det = '0;
   logic irq_level, irq_msi;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dispirq_ctrl #(.NUM_PIPES(NP), .NUM_PORTS(NH), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .user_evt(user_evt), .aux_evt(aux_evt), .pipe_evt(pipe_evt),
      .pipe_ovf(pipe_ovf), .hp_det(hp_det),
      .irq_level(irq_level), .irq_msi(irq_msi));

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      reg_addr = AW'(a); reg_wdata = d; reg_wr = 1'b1;
      step();
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      reg_addr = AW'(a); reg_rd = 1'b1;
      step();
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R1 reset state
      chk("R1 irq_level", 32'(irq_level), 0);
      chk("R1 irq_msi", 32'(irq_msi), 0);
      rd(0, v); chk("R1 IIR", v, 0);
      rd(1, v); chk("R1 IMR", v, 32'h1F);
      rd(2, v); chk("R1 IER", v, 32'h01);
      rd(3, v); chk("R1 HPSTAT", v, 0);
      rd(4, v); chk("R1 HPEN", v, 0);
      rd(8, v); chk("R1 PIPE0", v, 0);
      rd(9, v); chk("R1 PIPE1", v, 0);

      // R2 unused addresses read zero
      foreach (v[i]) begin end
      for (int a = 5; a < 16; a++) begin
         if (a != 8 && a != 9) begin
            rd(a, v); chk("R2 unused addr", v, 0);
         end
      end
      wr(2, 32'h16); rd(2, v); chk("R2 IER readback", v, 32'h16);

      // R5 sweep of enable/mask for user and aux sources
      for (int c = 0; c < 4; c++) begin
         for (int s = 0; s < 2; s++) begin
            logic e, m, x;
            e = c[0]; m = c[1]; x = e & ~m;
            wr(2, 32'(e) << s);
            wr(1, m ? (32'h1 << s) : 32'h0);
            if (s == 0) user_evt = 1'b1; else aux_evt = 1'b1;
            step();
            chk("R8 msi on first set", 32'(irq_msi), 32'(x));
            user_evt = 1'b0; aux_evt = 1'b0;
            rd(0, v); chk("R5 latch gating", v, 32'(x) << s);
            wr(0, 32'h1F);
         end
      end
      wr(2, 32'h1F); wr(1, 32'h0);

      // R3/R4 pipe status sweep, every status bit of every pipe
      for (int p = 0; p < NP; p++) begin
         for (int n = 0; n < 17; n++) begin
            logic [31:0] en, sb;
            logic intr;
            intr = (n < 15);
            en = intr ? (32'h1 << (n + 16)) : 32'h0;
            sb = (n == 16) ? 32'h8000_0000 : (32'h1 << n);
            wr(8 + p, en);
            if (n == 16) pipe_ovf[p] = 1'b1; else pipe_evt[p*16 + n] = 1'b1;
            step();
            pipe_evt = '0; pipe_ovf = '0;
            chk("R4 level from pipe status", 32'(irq_level), 32'(intr));
            step();
            chk("R8 msi from pipe", 32'(irq_msi), 32'(intr));
            rd(0, v); chk("R4 pipe IIR bit", v, intr ? (32'h1 << (3 + p)) : 32'h0);
            rd(8 + p, v); chk("R3 pipe status word", v, en | sb);
            wr(8 + p, v);
            rd(8 + p, v); chk("R3 write-back clears pending", v, en);
            wr(0, 32'h1F);
            wr(8 + p, 0);
            chk("R7 level idle", 32'(irq_level), 0);
         end
      end

      // R7 level held by pending pipe status, IIR not re-set
      wr(8, 32'h1 << 18);
      pipe_evt[2] = 1'b1; step(); pipe_evt = '0; step();
      rd(0, v); chk("R7 IIR pipe0 set", v, 32'h08);
      wr(0, 32'h08);
      rd(0, v); chk("R7 IIR cleared", v, 0);
      chk("R7 level held", 32'(irq_level), 1);
      repeat (3) step();
      rd(0, v); chk("R7 IIR not re-set", v, 0);
      chk("R8 no msi while held", 32'(irq_msi), 0);
      wr(8, 32'h0004_0004);
      chk("R7 level drops", 32'(irq_level), 0);
      wr(8, 0);

      // R8 only zero to non-zero pulses
      user_evt = 1'b1; step();
      chk("R8 msi first", 32'(irq_msi), 1);
      user_evt = 1'b0; step();
      chk("R8 msi one cycle", 32'(irq_msi), 0);
      aux_evt = 1'b1; step(); aux_evt = 1'b0;
      chk("R8 no msi when non-zero", 32'(irq_msi), 0);
      rd(0, v); chk("R8 both bits", v, 32'h3);
      wr(0, 32'h3); step();
      aux_evt = 1'b1; step(); aux_evt = 1'b0;
      chk("R8 msi again after zero", 32'(irq_msi), 1);
      wr(0, 32'h2);

      // R6 same-cycle event wins over clear
      user_evt = 1'b1; step(); user_evt = 1'b0; step();
      reg_addr = AW'(0); reg_wdata = 32'h1; reg_wr = 1'b1; user_evt = 1'b1;
      step();
      reg_wr = 1'b0; user_evt = 1'b0;
      rd(0, v); chk("R6 event wins clear", v, 32'h1);
      wr(0, 32'h1);
      rd(0, v); chk("R6 write-one clears", v, 0);

      // R3 pipe status collision
      wr(8, 32'h1 << 19);
      pipe_evt[3] = 1'b1; step(); pipe_evt = '0;
      reg_addr = AW'(8); reg_wdata = 32'h0008_0008; reg_wr = 1'b1; pipe_evt[3] = 1'b1;
      step();
      reg_wr = 1'b0; pipe_evt = '0;
      rd(8, v); chk("R3 event wins clear", v, 32'h0008_0008);
      wr(8, 32'h8); wr(8, 0); wr(0, 32'h1F);

      // R5 held source does not relatch
      user_evt = 1'b1; step();
      wr(0, 32'h1);
      repeat (2) step();
      rd(0, v); chk("R5 level source no relatch", v, 0);
      user_evt = 1'b0;

      // R9 hotplug
      wr(4, 0);
      hp_det = 4'b0010; step(); hp_det = '0;
      rd(3, v); chk("R9 hp sticky", v, 32'h2);
      rd(0, v); chk("R9 disabled no IIR", v, 0);
      wr(4, 32'h2); step();
      rd(0, v); chk("R9 enable raises IIR", v, 32'h4);
      wr(0, 32'h4);
      hp_det = 4'b1000; step(); hp_det = '0; step();
      rd(0, v); chk("R9 gated port", v, 0);
      rd(3, v); chk("R9 both sticky", v, 32'hA);
      wr(3, 32'hA);
      rd(3, v); chk("R9 write-one clears", v, 0);
      rd(4, v); chk("R9 enable readback", v, 32'h2);
      chk("R7 level final", 32'(irq_level), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule